// File: doc/BRIEF.md
# Write-Through Data Cache with DMA Snoop Invalidation

This block is a small direct-mapped data cache. It sits between a processor's byte-wide load/store port and a byte-wide memory port. Stores always go out to memory, so memory never holds an older value than the cache. When a store hits a resident line, the cached byte is updated as well. Loads that miss fetch the whole line from memory. Loads that hit are served from the local array.

Two mechanisms keep the cache consistent with agents it cannot see. First, a snoop port reports DMA writes, and any resident line whose address matches is dropped. Second, a single-cycle invalidate-all command empties the cache. A base/mask pair defines an uncached address window for memory-mapped peripherals. Accesses inside that window are never looked up and never allocate, so peripheral registers are always read from the device itself.

With the default parameters there are 16 lines of 4 bytes over a 16-bit byte address. The address splits into tag bits [15:6], index bits [5:2] and byte offset bits [1:0].

Top module: `wt_snoop_cache`

## Requirements
- R1: Every accepted store issues exactly one memory write with the store's address and data, then raises `cpu_rvalid` for one cycle.
- R2: A store whose line is resident also updates the cached byte. A later load of that byte returns the stored value with no memory access.
- R3: An address is uncached when `((addr ^ nc_base) & nc_mask) == 0`. Such a load or store makes exactly one memory access, and a repeated load of it again makes one memory access.
- R4: After `inv_all`, no line is valid, and the next load of any earlier-resident address refetches its line.
- R5: A snoop pulse (`snp_valid`) whose address lies in a resident line invalidates that line. The next load of that line refetches it and returns the DMA-written value.
- R6: A load miss performs four memory reads at line offsets 0, 1, 2, 3 in that order, and returns the requested byte. Later loads to the same line make no memory access.
- R7: A store miss does not allocate. A later load of that address performs a 4-read line fetch.
- R8: A snoop to the index of a line being filled, at any time during the fill, leaves that line invalid. The next load of it performs a full fill.
- R9: While `inv_all` is high, `cpu_busy` is high and no request is accepted in that cycle.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` stay stable into the next cycle.
- R11: After reset, `cpu_busy`, `cpu_rvalid` and `mem_req` are low and every line is invalid.
- R12: Two addresses with the same index but different tags evict each other. Alternating loads of them each perform a full fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid; accepted on an edge where `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_busy | output | 1 | Port cannot accept a request this cycle |
| cpu_rvalid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load data, valid with `cpu_rvalid` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| snp_valid | input | 1 | A DMA write was observed this cycle |
| snp_addr | input | 16 | Address of the observed DMA write |
| inv_all | input | 1 | Invalidate every line; stalls the CPU port for that cycle |
| nc_base | input | 16 | Uncached window base |
| nc_mask | input | 16 | Uncached window compare mask |

## Verification
The assertions check several properties on every cycle. Invalidate-all must leave no valid line and must block acceptance. Any store must reach the memory port. Any uncached access must take the single-access path. A pending memory request must hold its address. Only the bench's scenarios can show that a snoop actually removes the matching line, and that a fill raced by a snoop stays invalid. They also show write-hit update, no-allocate on store misses, and conflict eviction. The bench detects each of these by counting memory accesses and comparing returned bytes against its own memory model.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SINGLE,
    ST_HITRD,
    ST_FILL
  } cache_state_e;
endpackage

// File: rtl/wt_cache_tags.sv
module wt_cache_tags #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             clr_all,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_ok,
  output logic [LINES-1:0] vld_vec
);
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || clr_all)
        vld_vec[g] <= 1'b0;
      else if (fill_en && fill_idx == IDX_W'(g))
        vld_vec[g] <= fill_ok;
      else if (snp_en && snp_idx == IDX_W'(g) && tag_q[g] == snp_tag)
        vld_vec[g] <= 1'b0;
    end
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_vld = vld_vec[rd_idx];
endmodule

// File: rtl/wt_cache_data.sv
module wt_cache_data #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
    rd_data <= ram[rd_addr];
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              inv_all,
  input  logic [ADDR_W-1:0] nc_base,
  input  logic [ADDR_W-1:0] nc_mask
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int RAM_AW = IDX_W + OFF_W;
  localparam int DEPTH  = LINES * LINE_BYTES;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_BYTES - 1);

  cache_state_e      state_q;
  logic              rq_we, rq_nc, fill_kill_q;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic [OFF_W-1:0]  beat_q;

  logic [IDX_W-1:0]  rq_idx, snp_idx;
  logic [TAG_W-1:0]  rq_tag, snp_tag, look_tag;
  logic [OFF_W-1:0]  rq_off;
  logic              look_vld, hit, snp_same_idx;
  logic              fill_en, fill_ok;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic [LINES-1:0]  vld_vec;

  assign rq_off  = rq_addr[OFF_W-1:0];
  assign rq_idx  = rq_addr[OFF_W +: IDX_W];
  assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr[OFF_W +: IDX_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];

  assign hit          = look_vld && (look_tag == rq_tag);
  assign snp_same_idx = snp_valid && (snp_idx == rq_idx);
  assign fill_en      = (state_q == ST_FILL) && mem_ack && (beat_q == LAST_BEAT);
  assign fill_ok      = !fill_kill_q && !snp_same_idx && !inv_all;
  assign cpu_busy     = (state_q != ST_IDLE) || inv_all;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {rq_idx, rq_off};
    ram_wdata = rq_wdata;
    if (state_q == ST_FILL && mem_ack) begin
      ram_we    = 1'b1;
      ram_waddr = {rq_idx, beat_q};
      ram_wdata = mem_rdata;
    end else if (state_q == ST_SINGLE && mem_ack && rq_we && !rq_nc && hit) begin
      ram_we = 1'b1;
    end
  end

  wt_cache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rq_idx),
    .rd_tag   (look_tag),
    .rd_vld   (look_vld),
    .snp_en   (snp_valid),
    .snp_idx  (snp_idx),
    .snp_tag  (snp_tag),
    .clr_all  (inv_all),
    .fill_en  (fill_en),
    .fill_idx (rq_idx),
    .fill_tag (rq_tag),
    .fill_ok  (fill_ok),
    .vld_vec  (vld_vec)
  );

  wt_cache_data #(.DEPTH(DEPTH), .AW(RAM_AW), .DW(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_addr ({rq_idx, rq_off}),
    .rd_data (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rq_we       <= 1'b0;
      rq_nc       <= 1'b0;
      rq_addr     <= '0;
      rq_wdata    <= '0;
      beat_q      <= '0;
      fill_kill_q <= 1'b0;
      cpu_rvalid  <= 1'b0;
      cpu_rdata   <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req && !inv_all) begin
            rq_we    <= cpu_we;
            rq_addr  <= cpu_addr;
            rq_wdata <= cpu_wdata;
            rq_nc    <= ((cpu_addr ^ nc_base) & nc_mask) == '0;
            state_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (rq_nc || rq_we) begin
            mem_req   <= 1'b1;
            mem_we    <= rq_we;
            mem_addr  <= rq_addr;
            mem_wdata <= rq_wdata;
            state_q   <= ST_SINGLE;
          end else if (hit) begin
            state_q <= ST_HITRD;
          end else begin
            mem_req     <= 1'b1;
            mem_we      <= 1'b0;
            mem_addr    <= {rq_tag, rq_idx, OFF_W'(0)};
            beat_q      <= '0;
            fill_kill_q <= snp_same_idx || inv_all;
            state_q     <= ST_FILL;
          end
        end
        ST_HITRD: begin
          cpu_rvalid <= 1'b1;
          cpu_rdata  <= ram_q;
          state_q    <= ST_IDLE;
        end
        ST_SINGLE: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= rq_we ? rq_wdata : mem_rdata;
            state_q    <= ST_IDLE;
          end
        end
        ST_FILL: begin
          fill_kill_q <= fill_kill_q || snp_same_idx || inv_all;
          if (mem_ack) begin
            if (beat_q == rq_off) cpu_rdata <= mem_rdata;
            if (beat_q == LAST_BEAT) begin
              mem_req    <= 1'b0;
              cpu_rvalid <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              beat_q   <= beat_q + 1'b1;
              mem_addr <= mem_addr + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              inv_all,
  input logic [LINES-1:0]  vld_vec,
  input cache_state_e      state_q,
  input logic              rq_we,
  input logic              rq_nc
);
  AST_STORE_REACHES_MEM: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && rq_we) |=> (mem_req && mem_we)); // R1

  AST_UNCACHED_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && rq_nc) |=> (state_q == ST_SINGLE)); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (vld_vec == '0)); // R4

  AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (rst)
    (inv_all && cpu_req && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R9

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_req  (cpu_req),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .inv_all  (inv_all),
  .vld_vec  (vld_vec),
  .state_q  (state_q),
  .rq_we    (rq_we),
  .rq_nc    (rq_nc)
);

// File: tb/wt_snoop_cache_test.sv
`timescale 1ns/1ps
module wt_snoop_cache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_busy, cpu_rvalid;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [15:0] snp_addr = '0;
  logic        inv_all = 1'b0;
  logic [15:0] nc_base = 16'hF000, nc_mask = 16'hF000;

  always #2.5 clk = ~clk;

  wt_snoop_cache uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .inv_all(inv_all),
    .nc_base(nc_base), .nc_mask(nc_mask)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R6";

  task automatic chk(bit ok, string rq, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // Memory model: default content derived from the address, overridden by writes.
  logic [7:0] ovr [int];
  function automatic logic [7:0] rd_val(logic [15:0] a);
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  int lat = 0, wait_c = 0, acc_cnt = 0, hold_err = 0;
  logic [15:0] beats [$];
  logic        last_wait = 1'b0;
  logic [15:0] last_addr = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      wait_c    <= 0;
      last_wait <= 1'b0;
    end else begin
      if (last_wait && mem_addr != last_addr) hold_err <= hold_err + 1;
      last_wait <= mem_req && !mem_ack && (wait_c != lat);
      last_addr <= mem_addr;
      if (mem_req && !mem_ack) begin
        if (wait_c == lat) begin
          wait_c  <= 0;
          mem_ack <= 1'b1;
          acc_cnt <= acc_cnt + 1;
          beats.push_back(mem_addr);
          if (mem_we) ovr[int'(mem_addr)] = mem_wdata;
          else mem_rdata <= rd_val(mem_addr);
        end else begin
          wait_c <= wait_c + 1;
        end
      end
    end
  end

  // Scoreboard: -1 marks a store completion, otherwise the expected load byte.
  int exq [$];
  int pend = 0;

  always @(negedge clk) begin
    if (!rst && cpu_rvalid) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R1", 1, 0);
      end else begin
        int e;
        e = exq.pop_front();
        if (e >= 0) chk(cpu_rdata == e[7:0], cur_req, int'(cpu_rdata), e);
        pend--;
      end
    end
  end

  task automatic cpu_issue(bit we, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    exq.push_back(we ? -1 : int'(rd_val(a)));
    pend++;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic cpu_wait();
    wait (pend == 0);
    @(negedge clk);
  endtask

  task automatic rd(logic [15:0] a, int exp_acc, string rq);
    int base;
    base = acc_cnt;
    cur_req = rq;
    cpu_issue(1'b0, a, 8'h00);
    cpu_wait();
    chk(acc_cnt - base == exp_acc, rq, acc_cnt - base, exp_acc);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string rq);
    int base;
    base = acc_cnt;
    cur_req = rq;
    cpu_issue(1'b1, a, d);
    cpu_wait();
    chk(acc_cnt - base == 1, rq, acc_cnt - base, 1);
    chk(rd_val(a) == d, rq, int'(rd_val(a)), int'(d));
  endtask

  task automatic dma_write(logic [15:0] a, logic [7:0] v);
    @(negedge clk);
    ovr[int'(a)] = v;
    snp_valid = 1'b1; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: idle outputs after reset
    chk(cpu_busy == 1'b0, "R11", int'(cpu_busy), 0);
    chk(cpu_rvalid == 1'b0, "R11", int'(cpu_rvalid), 0);
    chk(mem_req == 1'b0, "R11", int'(mem_req), 0);
    rd(16'h4444, 4, "R11");

    // R6: line fill order and later hits
    beats.delete();
    rd(16'h1235, 4, "R6");
    for (int i = 0; i < 4; i++)
      chk(beats[i] == 16'h1234 + 16'(i), "R6", int'(beats[i]), 16'h1234 + i);
    rd(16'h1236, 0, "R6");
    rd(16'h1237, 0, "R6");

    // R1 / R2: store hit goes out and updates the cached byte
    wr(16'h1236, 8'hA5, "R1");
    rd(16'h1236, 0, "R2");

    // R7: store miss does not allocate
    wr(16'h2000, 8'h11, "R7");
    rd(16'h2000, 4, "R7");

    // R3: uncached window, with slower memory
    lat = 2;
    rd(16'hF010, 1, "R3");
    rd(16'hF010, 1, "R3");
    wr(16'hF011, 8'h3C, "R3");
    rd(16'hF011, 1, "R3");
    nc_base = 16'h8000; nc_mask = 16'hFF00;
    rd(16'h8004, 1, "R3");
    rd(16'hF010, 4, "R3");
    rd(16'hF010, 0, "R3");
    nc_base = 16'hF000; nc_mask = 16'hF000;

    // R5: snoop invalidates a resident line
    dma_write(16'h1234, 8'h77);
    rd(16'h1234, 4, "R5");
    rd(16'h1237, 0, "R5");
    dma_write(16'h9234, 8'h01);
    rd(16'h1235, 0, "R5");

    // R12: conflicting tags on one index
    rd(16'h5234, 4, "R12");
    rd(16'h1234, 4, "R12");
    rd(16'h5234, 4, "R12");

    // R9 / R4: invalidate-all stalls the port and empties the cache
    lat = 0;
    rd(16'h2000, 0, "R4");
    @(negedge clk);
    inv_all = 1'b1;
    #0.5;
    chk(cpu_busy == 1'b1, "R9", int'(cpu_busy), 1);
    @(negedge clk);
    inv_all = 1'b0;
    rd(16'h2000, 4, "R4");
    rd(16'h5235, 4, "R4");

    // R8: snoop to the filling index during the fill
    lat = 1;
    begin
      int base;
      base = acc_cnt;
      cur_req = "R8";
      cpu_issue(1'b0, 16'h3001, 8'h00);
      while (acc_cnt < base + 2) @(negedge clk);
      dma_write(16'h7000, 8'h42);
      cpu_wait();
      chk(acc_cnt - base == 4, "R8", acc_cnt - base, 4);
    end
    rd(16'h3001, 4, "R8");
    rd(16'h3002, 0, "R8");

    // R10: request held while memory is slow
    chk(hold_err == 0, "R10", hold_err, 0);
    chk(exq.size() == 0, "R1", exq.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule